// File: doc/BRIEF.md
# System Control and Microsecond Timing Registers

This block sits on a 16-bit-address I/O bus and serves a handful of system control registers to the CPU through byte or halfword accesses. It records why the machine last restarted (a software-requested reset or a CPU halt), and clears that record when software reads it. It reports a combined machine and CPU identity byte, and runs a 16-bit counter that advances once per microsecond. The counter is paced by an internal clock divider, so software can measure short intervals by reading it twice.

Writes to the control register request a CPU software reset and choose between a full 32-bit and a narrow 20-bit CPU address mask. Writes to either the control register or the power register can halt the CPU and request power-off. A write to the wait register holds the CPU off the bus for exactly one microsecond by raising a bus request. This only happens on machines whose identity number is at or above a threshold.

Read data is combinational from the address and the current state. Writes and clear-on-read side effects take effect at the clock edge that ends the access.

Top module: `sysctl_timer_regs`

## Requirements
- R1: After reset the cause byte at offset 0x20 reads 0x7C, the counter reads 0, the address mask is 0xFFFFFFFF, and the bus request, soft-reset and power-off outputs are low.
- R2: A byte read of offset 0x20 returns bit0 = software-reset flag, bit1 = halt flag, bits 6..2 = 1 and bit7 = 0.
- R3: Any read that covers offset 0x20 (a byte read at 0x20, or a halfword read at 0x20) clears both flags for later reads; a byte read of 0x21 clears nothing.
- R4: A write to 0x20 loads the software-reset flag from data bit0; when bit0 is 1, `soft_reset_o` is high for exactly the one cycle after the write edge.
- R5: A write to 0x20 or 0x22 with data bit6 set sets the halt flag and raises `power_off_o` for the one cycle after the write edge; with bit6 clear neither happens.
- R6: A write to 0x20 sets `addr_mask_o` to 0x000FFFFF when data bit3 is 1 and to 0xFFFFFFFF when it is 0.
- R7: The counter advances by one every CLKS_PER_US clocks from reset (value = floor(edges since reset / CLKS_PER_US) mod 2^16). A byte read at 0x26 gives its low byte, a byte read at 0x27 gives its high byte, and a halfword read at 0x26 gives all 16 bits.
- R8: The counter wraps from 0xFFFF to 0x0000.
- R9: A byte read at 0x30 returns {machine_id[4:0], cpu_id[2:0]}.
- R10: A write (byte or halfword) to 0x6C while machine_id >= WAIT_MIN_ID (default 0x0300) raises `bus_req_o` for exactly CLKS_PER_US cycles, starting in the cycle after the write edge. A byte read at 0x6C gives bit0 = bus request active, with bits 7..1 set to 1.
- R11: A write to 0x6C while machine_id < WAIT_MIN_ID leaves `bus_req_o` low.
- R12: A write to 0x6C during an active wait restarts the full CLKS_PER_US interval from that write's edge.
- R13: A halfword read at even address A returns {byte(A+1), byte(A)}. A byte read of any offset other than 0x20, 0x26, 0x27, 0x30 and 0x6C returns 0xFF, and a byte read places zeros in bits 15..8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O byte address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_half | input | 1 | 1 = halfword access, 0 = byte access |
| io_wdata | input | 16 | Write data; bits 7..0 carry the byte written at the even offset |
| io_rdata | output | 16 | Read data for the current address |
| machine_id | input | 16 | Machine identity number |
| cpu_id | input | 3 | CPU identity code |
| soft_reset_o | output | 1 | One-cycle software reset request |
| power_off_o | output | 1 | One-cycle halt and power-off request |
| addr_mask_o | output | 32 | CPU address mask |
| bus_req_o | output | 1 | Bus request that holds the CPU during a wait |

## Verification
Read data is due in the same cycle as the strobe, so the bench samples `io_rdata` one step after the negative edge on which it drives the access. It then lets the positive edge pass, which is when the flags clear. The reset and power-off pulses and the address mask are due one edge after the write, and are sampled on the negative edge that follows it. The bus request is counted over the negative edges after the write and must total CLKS_PER_US, or one more cycle when a second write restarts the wait. The bench counts every positive edge since reset, so it can work out the counter value for any sample as that count divided by the divider setting, including the two samples on either side of the wrap.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam logic [15:0] OFS_CAUSE  = 16'h0020;
    localparam logic [15:0] OFS_POWER  = 16'h0022;
    localparam logic [15:0] OFS_CNT_LO = 16'h0026;
    localparam logic [15:0] OFS_CNT_HI = 16'h0027;
    localparam logic [15:0] OFS_IDENT  = 16'h0030;
    localparam logic [15:0] OFS_WAIT   = 16'h006C;

    localparam logic [7:0]  CAUSE_ONES = 8'h7C;
    localparam logic [7:0]  OPEN_BYTE  = 8'hFF;

    localparam int BIT_SWRST  = 0;
    localparam int BIT_NARROW = 3;
    localparam int BIT_HALT   = 6;

    // True when an access of the given size covers the even offset ofs.
    function automatic logic covers(input logic [15:0] a,
                                    input logic        half,
                                    input logic [15:0] ofs);
        return half ? (a[15:1] == ofs[15:1]) : (a == ofs);
    endfunction

endpackage

// File: rtl/sysctl_tick_div.sv
module sysctl_tick_div #(
    parameter int CLKS_PER_US = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (CLKS_PER_US <= 1) begin : g_every
            logic unused_in;
            assign unused_in = clk ^ rst_n;
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(CLKS_PER_US);
            localparam logic [DW-1:0] LAST = DW'(CLKS_PER_US - 1);

            logic [DW-1:0] div_d, div_q;

            always_comb begin
                div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end

            assign tick = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/sysctl_wait_ctl.sv
module sysctl_wait_ctl #(
    parameter int CLKS_PER_US = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CLKS_PER_US + 1);
    localparam logic [CW-1:0] LOAD = CW'(CLKS_PER_US);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] left;
    } wait_t;

    wait_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.left = LOAD;
        end else if (st_q.busy) begin
            if (st_q.left == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.left = '0;
            end else begin
                st_d.left = st_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
endmodule

// File: rtl/sysctl_timer_regs.sv
module sysctl_timer_regs
    import sysctl_pkg::*;
#(
    parameter int               CLKS_PER_US = 16,
    parameter int               CNT_W       = 16,
    parameter int               ID_W        = 16,
    parameter logic [ID_W-1:0]  WAIT_MIN_ID = 'h0300,
    parameter int               AMASK_W     = 32,
    parameter int               NARROW_W    = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        io_addr,
    input  logic               io_rd,
    input  logic               io_wr,
    input  logic               io_half,
    input  logic [15:0]        io_wdata,
    output logic [15:0]        io_rdata,
    input  logic [ID_W-1:0]    machine_id,
    input  logic [2:0]         cpu_id,
    output logic               soft_reset_o,
    output logic               power_off_o,
    output logic [AMASK_W-1:0] addr_mask_o,
    output logic               bus_req_o
);
    localparam logic [AMASK_W-1:0] MASK_FULL   = '1;
    localparam logic [AMASK_W-1:0] MASK_NARROW = {{(AMASK_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    typedef struct packed {
        logic             sw_flag;
        logic             sd_flag;
        logic             narrow;
        logic [CNT_W-1:0] ctr;
        logic             srst_pulse;
        logic             poff_pulse;
    } state_t;

    state_t st_d, st_q;

    logic tick;
    logic wait_go;
    logic wait_busy;
    logic [15:0] ctr16;
    logic [7:0]  ident;
    logic [15:0] base_a;
    logic [7:0]  byte_lo, byte_hi;
    logic        unused_bits;

    sysctl_tick_div #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    assign wait_go = io_wr && covers(io_addr, io_half, OFS_WAIT)
                     && (machine_id >= WAIT_MIN_ID);

    sysctl_wait_ctl #(.CLKS_PER_US(CLKS_PER_US)) u_wait (
        .clk  (clk),
        .rst_n(rst_n),
        .start(wait_go),
        .busy (wait_busy)
    );

    // Next-state logic for flags, mask select, counter and pulses.
    always_comb begin
        st_d            = st_q;
        st_d.srst_pulse = 1'b0;
        st_d.poff_pulse = 1'b0;
        if (tick) st_d.ctr = st_q.ctr + 1'b1;
        if (io_wr) begin
            if (covers(io_addr, io_half, OFS_CAUSE)) begin
                st_d.sw_flag    = io_wdata[BIT_SWRST];
                st_d.srst_pulse = io_wdata[BIT_SWRST];
                st_d.narrow     = io_wdata[BIT_NARROW];
                if (io_wdata[BIT_HALT]) begin
                    st_d.sd_flag    = 1'b1;
                    st_d.poff_pulse = 1'b1;
                end
            end
            if (covers(io_addr, io_half, OFS_POWER) && io_wdata[BIT_HALT]) begin
                st_d.sd_flag    = 1'b1;
                st_d.poff_pulse = 1'b1;
            end
        end else if (io_rd && covers(io_addr, io_half, OFS_CAUSE)) begin
            st_d.sw_flag = 1'b0;
            st_d.sd_flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    function automatic logic [7:0] byte_at(input logic [15:0] a,
                                           input logic        sw,
                                           input logic        sd,
                                           input logic [15:0] cnt,
                                           input logic [7:0]  idb,
                                           input logic        bsy);
        logic [7:0] r;
        case (a)
            OFS_CAUSE:  r = CAUSE_ONES | {6'b0, sd, sw};
            OFS_CNT_LO: r = cnt[7:0];
            OFS_CNT_HI: r = cnt[15:8];
            OFS_IDENT:  r = idb;
            OFS_WAIT:   r = {7'h7F, bsy};
            default:    r = OPEN_BYTE;
        endcase
        return r;
    endfunction

    assign ctr16  = 16'(st_q.ctr);
    assign ident  = {machine_id[4:0], cpu_id};
    assign base_a = io_half ? {io_addr[15:1], 1'b0} : io_addr;

    always_comb begin
        byte_lo = byte_at(base_a, st_q.sw_flag, st_q.sd_flag, ctr16, ident, wait_busy);
        byte_hi = byte_at({base_a[15:1], 1'b1}, st_q.sw_flag, st_q.sd_flag, ctr16, ident, wait_busy);
        io_rdata = io_half ? {byte_hi, byte_lo} : {8'h00, byte_lo};
    end

    assign soft_reset_o = st_q.srst_pulse;
    assign power_off_o  = st_q.poff_pulse;
    assign addr_mask_o  = st_q.narrow ? MASK_NARROW : MASK_FULL;
    assign bus_req_o    = wait_busy;

    assign unused_bits = ^{io_wdata[15:7], io_wdata[5:4], io_wdata[2:1]};
endmodule

// File: rtl/sysctl_timer_regs_chk.sv
module sysctl_timer_regs_chk
    import sysctl_pkg::*;
#(
    parameter int              CNT_W       = 16,
    parameter int              ID_W        = 16,
    parameter logic [ID_W-1:0] WAIT_MIN_ID = 'h0300,
    parameter int              AMASK_W     = 32,
    parameter int              NARROW_W    = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic [15:0]        io_addr,
    input logic               io_rd,
    input logic               io_wr,
    input logic               io_half,
    input logic [15:0]        io_wdata,
    input logic [ID_W-1:0]    machine_id,
    input logic               soft_reset_o,
    input logic               power_off_o,
    input logic [AMASK_W-1:0] addr_mask_o,
    input logic               bus_req_o,
    input logic               sw_flag,
    input logic               sd_flag,
    input logic [CNT_W-1:0]   ctr
);
    localparam logic [AMASK_W-1:0] M_FULL   = '1;
    localparam logic [AMASK_W-1:0] M_NARROW = {{(AMASK_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic cause_rd, cause_wr, power_wr, wait_wr;
    assign cause_rd = io_rd && !io_wr && covers(io_addr, io_half, OFS_CAUSE);
    assign cause_wr = io_wr && covers(io_addr, io_half, OFS_CAUSE);
    assign power_wr = io_wr && covers(io_addr, io_half, OFS_POWER);
    assign wait_wr  = io_wr && covers(io_addr, io_half, OFS_WAIT);

    a_r3_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        cause_rd |=> (!sw_flag && !sd_flag));

    a_r4_reset_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_reset_o) |-> $past(cause_wr && io_wdata[0]));

    a_r5_poweroff_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(power_off_o) |-> $past((cause_wr || power_wr) && io_wdata[6]));

    a_r5_halt_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_wr || power_wr) && io_wdata[6]) |=> (sd_flag && power_off_o));

    a_r6_mask_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        cause_wr |=> (addr_mask_o == ($past(io_wdata[3]) ? M_NARROW : M_FULL)));

    a_r6_mask_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_mask_o == M_FULL) || (addr_mask_o == M_NARROW));

    a_r7_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr != $past(ctr)) |-> (ctr == CNT_W'($past(ctr) + 1'b1)));

    a_r10_wait_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_wr && machine_id >= WAIT_MIN_ID) |=> bus_req_o);

    a_r11_wait_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req_o) |-> $past(wait_wr && machine_id >= WAIT_MIN_ID));
endmodule

bind sysctl_timer_regs sysctl_timer_regs_chk #(
    .CNT_W      (CNT_W),
    .ID_W       (ID_W),
    .WAIT_MIN_ID(WAIT_MIN_ID),
    .AMASK_W    (AMASK_W),
    .NARROW_W   (NARROW_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .io_half     (io_half),
    .io_wdata    (io_wdata),
    .machine_id  (machine_id),
    .soft_reset_o(soft_reset_o),
    .power_off_o (power_off_o),
    .addr_mask_o (addr_mask_o),
    .bus_req_o   (bus_req_o),
    .sw_flag     (st_q.sw_flag),
    .sd_flag     (st_q.sd_flag),
    .ctr         (st_q.ctr)
);

// File: tb/sysctl_timer_regs_tb.sv
module sysctl_timer_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0, io_half = 1'b0;
    logic [15:0] io_wdata = '0;
    logic [15:0] io_rdata;
    logic [15:0] machine_id = 16'h0300;
    logic [2:0]  cpu_id = 3'd0;
    logic        soft_reset_o, power_off_o, bus_req_o;
    logic [31:0] addr_mask_o;

    int n_tests = 0;
    int n_fail  = 0;
    int edge_n  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) edge_n = 0;
        else        edge_n = edge_n + 1;
    end

    sysctl_timer_regs #(.CLKS_PER_US(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_half(io_half), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .machine_id(machine_id), .cpu_id(cpu_id), .soft_reset_o(soft_reset_o),
        .power_off_o(power_off_o), .addr_mask_o(addr_mask_o), .bus_req_o(bus_req_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] cnt_now();
        return 16'((edge_n / DIV) % 65536);
    endfunction

    // Starts and ends on a negative edge; returns data seen during the access.
    task automatic rd(input logic [15:0] a, input logic half, output logic [15:0] d,
                      output logic [15:0] expc);
        io_addr = a; io_half = half; io_rd = 1'b1;
        #1;
        d    = io_rdata;
        expc = cnt_now();
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic half, input logic [15:0] d);
        io_addr = a; io_half = half; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic count_busy(output int hi);
        hi = 0;
        for (int k = 0; k < 8; k++) begin
            if (bus_req_o) hi++;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [15:0] d, e;
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(16'h0026, 1'b1, d, e);
        chk("R1 counter", {16'h0, d}, 32'h0);
        chk("R1 mask", addr_mask_o, 32'hFFFF_FFFF);
        chk("R1 outputs", {29'h0, bus_req_o, soft_reset_o, power_off_o}, 32'h0);
        rd(16'h0020, 1'b0, d, e);
        chk("R1 cause", {16'h0, d}, 32'h7C);

        // R4 software reset flag and pulse
        wr(16'h0020, 1'b0, 16'h0001);
        chk("R4 pulse high", {31'h0, soft_reset_o}, 1);
        chk("R6 bit3 clear full mask", addr_mask_o, 32'hFFFF_FFFF);
        rd(16'h0020, 1'b0, d, e);
        chk("R4 pulse one cycle", {31'h0, soft_reset_o}, 0);
        chk("R2 sw flag", {16'h0, d}, 32'h7D);
        rd(16'h0020, 1'b0, d, e);
        chk("R3 cleared", {16'h0, d}, 32'h7C);
        wr(16'h0020, 1'b0, 16'h0001);
        wr(16'h0020, 1'b0, 16'h0000);
        chk("R4 bit0 clear no pulse", {31'h0, soft_reset_o}, 0);
        rd(16'h0020, 1'b0, d, e);
        chk("R4 bit0 clears flag", {16'h0, d}, 32'h7C);

        // R5 halt / power off
        wr(16'h0022, 1'b0, 16'h0040);
        chk("R5 poweroff via 0x22", {31'h0, power_off_o}, 1);
        rd(16'h0020, 1'b0, d, e);
        chk("R5 pulse one cycle", {31'h0, power_off_o}, 0);
        chk("R2 halt flag", {16'h0, d}, 32'h7E);
        rd(16'h0020, 1'b0, d, e);
        chk("R3 halt cleared", {16'h0, d}, 32'h7C);
        wr(16'h0020, 1'b0, 16'h0041);
        chk("R5 poweroff via 0x20", {30'h0, power_off_o, soft_reset_o}, 32'h3);
        rd(16'h0020, 1'b0, d, e);
        chk("R2 both flags", {16'h0, d}, 32'h7F);
        wr(16'h0022, 1'b0, 16'h00BF);
        chk("R5 bit6 clear no poweroff", {31'h0, power_off_o}, 0);
        rd(16'h0020, 1'b0, d, e);
        chk("R5 bit6 clear no flag", {16'h0, d}, 32'h7C);

        // R3 byte 0x21 leaves flags; halfword 0x20 clears; R13 upper byte
        wr(16'h0020, 1'b0, 16'h0001);
        rd(16'h0021, 1'b0, d, e);
        chk("R13 byte 0x21 open", {16'h0, d}, 32'hFF);
        rd(16'h0020, 1'b1, d, e);
        chk("R3 0x21 read kept flag, R13 half", {16'h0, d}, 32'hFF7D);
        rd(16'h0020, 1'b0, d, e);
        chk("R3 half read clears", {16'h0, d}, 32'h7C);

        // R6 address mask
        wr(16'h0020, 1'b0, 16'h0008);
        chk("R6 narrow", addr_mask_o, 32'h000F_FFFF);
        wr(16'h0020, 1'b0, 16'h0000);
        chk("R6 full", addr_mask_o, 32'hFFFF_FFFF);
        wr(16'h0020, 1'b1, 16'h0008);
        chk("R6 narrow via halfword", addr_mask_o, 32'h000F_FFFF);
        wr(16'h0020, 1'b1, 16'h0000);

        // R9 exhaustive identity sweep
        for (int m = 0; m < 32; m++) begin
            for (int c = 0; c < 8; c++) begin
                machine_id = 16'h0300 | 16'(m);
                cpu_id = 3'(c);
                rd(16'h0030, 1'b0, d, e);
                chk("R9 ident", {16'h0, d}, 32'(m * 8 + c));
            end
        end
        machine_id = 16'h0315; cpu_id = 3'd6;
        rd(16'h0030, 1'b1, d, e);
        chk("R13 half ident", {16'h0, d}, 32'hFFAE);

        // R10 / R11 wait gating over identity numbers
        begin
            logic [15:0] ids [6] = '{16'h0000, 16'h02FF, 16'h0300, 16'h0301, 16'h1234, 16'hFFFF};
            for (int i = 0; i < 6; i++) begin
                machine_id = ids[i];
                wr(16'h006C, (i % 2) == 1, 16'h0000);
                count_busy(hi);
                chk(ids[i] >= 16'h0300 ? "R10 wait length" : "R11 wait gated",
                    32'(hi), ids[i] >= 16'h0300 ? 32'(DIV) : 32'd0);
            end
        end
        machine_id = 16'h0300;
        wr(16'h006C, 1'b0, 16'h0000);
        rd(16'h006C, 1'b0, d, e);
        chk("R10 busy readback", {16'h0, d}, 32'hFF);
        repeat (4) @(negedge clk);
        rd(16'h006C, 1'b0, d, e);
        chk("R10 idle readback", {16'h0, d}, 32'hFE);

        // R12 restart
        wr(16'h006C, 1'b0, 16'h0000);
        hi = bus_req_o ? 1 : 0;
        wr(16'h006C, 1'b0, 16'h0000);
        begin
            int more;
            count_busy(more);
            chk("R12 restart length", 32'(hi + more), 32'(DIV + 1));
        end

        // R13 open addresses
        rd(16'h0100, 1'b0, d, e);
        chk("R13 open byte", {16'h0, d}, 32'hFF);
        rd(16'h0100, 1'b1, d, e);
        chk("R13 open half", {16'h0, d}, 32'hFFFF);
        rd(16'h006C, 1'b1, d, e);
        chk("R13 half wait", {16'h0, d}, 32'hFFFE);

        // R7 counter byte / halfword reads at varied phases
        for (int i = 0; i < 60; i++) begin
            repeat (i % 5) @(negedge clk);
            case (i % 3)
                0: begin rd(16'h0026, 1'b1, d, e); chk("R7 half", {16'h0, d}, {16'h0, e}); end
                1: begin rd(16'h0026, 1'b0, d, e); chk("R7 low byte", {16'h0, d}, {24'h0, e[7:0]}); end
                default: begin rd(16'h0027, 1'b0, d, e); chk("R7 high byte", {16'h0, d}, {24'h0, e[15:8]}); end
            endcase
        end

        // R8 wrap
        while (edge_n < 65535 * DIV) @(negedge clk);
        rd(16'h0026, 1'b1, d, e);
        chk("R8 top value", {16'h0, d}, 32'hFFFF);
        while (edge_n < 65536 * DIV) @(negedge clk);
        rd(16'h0026, 1'b1, d, e);
        chk("R8 wrapped", {16'h0, d}, 32'h0000);
        rd(16'h0027, 1'b0, d, e);
        chk("R8 high byte after wrap", {16'h0, d}, {24'h0, e[15:8]});

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule